// File: doc/BRIEF.md
# Single-Channel Byte-Copy DMA with Extended Addressing

This block is one DMA channel that copies bytes from a source region to a destination region through a plain memory port. Software programs it through a small word-wide register port: base addresses, byte counts, a cell length, a pattern byte and control bits. It then starts the transfer by writing a force bit. While the channel runs, one byte moves every cycle. The byte is read combinationally at the source address, and the matching destination write is issued from registers one cycle later.

In the normal addressing mode, source and destination each have their own 8-bit size and 8-bit pointer. The block length is the larger of the two sizes, and each start moves one cell. When the extended-addressing control bit is set, the two size bytes form one 16-bit length and the two pointers form one 16-bit pointer. In that mode one start moves the whole block. The channel raises flags for block completion, abort and error, and drives a registered interrupt line from them.

Top module: `dma_ext_channel`

Register map (word address : content). 0 control: bit 7 enable, bit 4 auto-enable, bit 3 extended mode. 1 event control: bit 7 force start (write-only), bit 5 pattern stop. 2 interrupt: flags at bit 3 block done, bit 1 abort, bit 0 error; enables at bits 11, 9, 8 for the same three. 3 source base. 4 destination base. 5 source size. 6 destination size. 7 source pointer (read-only). 8 destination pointer (read-only). 9 cell size. 10 cell pointer (read-only). 11 pattern byte. Register reads return on `reg_rdata` one clock after `reg_addr` is presented.

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and no memory write occurs.
- R2: In normal mode, byte i is read at source base + (i mod source size) and written to destination base + (i mod destination size). The block length is the larger of the two sizes, and a size of 0 means 256.
- R3: In normal mode each start moves cell-size bytes (0 means 256), then the channel waits for the next start with its enable still set.
- R4: With control bit 3 set, the length is {source size, destination size}, where 0 means 65536. Byte i goes from source base + i to destination base + i. One start moves the whole block, and the cell size is ignored.
- R5: In extended mode, the destination pointer register reads the full 16-bit count of bytes moved, and the source pointer register reads its upper byte.
- R6: Finishing a block sets interrupt bit 3 and clears control bit 7, unless control bit 4 (auto-enable) is set, in which case bit 7 stays set.
- R7: Writing event bit 7 starts a transfer only when the enable is set. With the enable clear, it sets interrupt bit 0 and moves nothing.
- R8: With event bit 5 set, the first byte equal to the pattern register is the last one written, and it completes the block.
- R9: Clearing control bit 7 during a transfer stops it at once, sets interrupt bit 1 and returns the pointers to 0.
- R10: `irq` is 1 one cycle after any flag is set together with its enable, and 0 one cycle after none is.
- R11: A running transfer writes one byte every cycle with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for `reg_addr` |
| mem_re | output | 1 | Source read active this cycle |
| mem_raddr | output | 16 | Source byte address |
| mem_rdata | input | 8 | Source byte, valid in the same cycle |
| mem_we | output | 1 | Destination write strobe |
| mem_waddr | output | 16 | Destination byte address |
| mem_wdata | output | 8 | Destination byte |
| irq | output | 1 | Channel interrupt request |

## Verification
Normal-mode copies use unequal source and destination sizes. This separates per-side wrap-around from a single shared pointer. Random sizes and bases are mixed with fixed cases. A short cell inside a longer block shows whether the channel pauses between starts. Extended-mode blocks of 300 bytes, 1024 bytes with a mid-run abort, and the zero-size 65536-byte case show whether the size bytes concatenate correctly and whether a cell length leaks into the extended mode. A pattern taken from a known source byte checks that the copy stops on exactly the first matching byte and not one byte before or after it.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int RAW = 4;

  typedef enum logic [RAW-1:0] {
    R_CTRL = 4'd0,
    R_ECON = 4'd1,
    R_INT  = 4'd2,
    R_SSA  = 4'd3,
    R_DSA  = 4'd4,
    R_SSZ  = 4'd5,
    R_DSZ  = 4'd6,
    R_SPTR = 4'd7,
    R_DPTR = 4'd8,
    R_CSZ  = 4'd9,
    R_CPTR = 4'd10,
    R_PAT  = 4'd11
  } reg_sel_e;

  localparam int B_EN    = 7;
  localparam int B_AUTO  = 4;
  localparam int B_EXT   = 3;
  localparam int B_FORCE = 7;
  localparam int B_PATEN = 5;
  localparam int B_BC    = 3;
  localparam int B_AB    = 1;
  localparam int B_ER    = 0;
  localparam int IEN_OFS = 8;
endpackage

// File: rtl/dmx_regs.sv
module dmx_regs import dmx_pkg::*; #(
  parameter int AW  = 16,
  parameter int BW  = 8,
  parameter int RW  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [RW-1:0]   reg_wdata,
  output logic [RW-1:0]   reg_rdata,
  input  logic [BW-1:0]   sptr_view,
  input  logic [2*BW-1:0] dptr_view,
  input  logic [BW:0]     cptr_view,
  input  logic            busy,
  input  logic            blk_done,
  output logic            cfg_en,
  output logic            cfg_ext,
  output logic            cfg_auto,
  output logic            cfg_paten,
  output logic [AW-1:0]   cfg_ssa,
  output logic [AW-1:0]   cfg_dsa,
  output logic [BW-1:0]   cfg_ssz,
  output logic [BW-1:0]   cfg_dsz,
  output logic [BW-1:0]   cfg_csz,
  output logic [BW-1:0]   cfg_pat,
  output logic            start_p,
  output logic            abort_p,
  output logic            err_p,
  output logic [2:0]      flags,
  output logic [2:0]      ien,
  output logic            irq
);
  reg_sel_e sel;
  logic     wr_ctrl, wr_int;
  logic [2:0] flg_base;

  assign sel     = reg_sel_e'(reg_addr);
  assign wr_ctrl = reg_wr && (sel == R_CTRL);
  assign wr_int  = reg_wr && (sel == R_INT);
  assign start_p = reg_wr && (sel == R_ECON) && reg_wdata[B_FORCE];
  assign abort_p = wr_ctrl && !reg_wdata[B_EN] && cfg_en && busy;
  assign err_p   = start_p && !cfg_en;

  always_comb begin
    flg_base = flags;
    if (wr_int) flg_base = {reg_wdata[B_BC], reg_wdata[B_AB], reg_wdata[B_ER]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en    <= 1'b0;
      cfg_ext   <= 1'b0;
      cfg_auto  <= 1'b0;
      cfg_paten <= 1'b0;
      cfg_ssa   <= '0;
      cfg_dsa   <= '0;
      cfg_ssz   <= '0;
      cfg_dsz   <= '0;
      cfg_csz   <= '0;
      cfg_pat   <= '0;
      flags     <= '0;
      ien       <= '0;
      irq       <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        cfg_en   <= reg_wdata[B_EN];
        cfg_ext  <= reg_wdata[B_EXT];
        cfg_auto <= reg_wdata[B_AUTO];
      end else if (blk_done && !cfg_auto) begin
        cfg_en <= 1'b0;
      end
      if (reg_wr) begin
        case (sel)
          R_ECON: cfg_paten <= reg_wdata[B_PATEN];
          R_SSA:  cfg_ssa   <= reg_wdata[AW-1:0];
          R_DSA:  cfg_dsa   <= reg_wdata[AW-1:0];
          R_SSZ:  cfg_ssz   <= reg_wdata[BW-1:0];
          R_DSZ:  cfg_dsz   <= reg_wdata[BW-1:0];
          R_CSZ:  cfg_csz   <= reg_wdata[BW-1:0];
          R_PAT:  cfg_pat   <= reg_wdata[BW-1:0];
          R_INT:  ien <= {reg_wdata[IEN_OFS+B_BC], reg_wdata[IEN_OFS+B_AB],
                          reg_wdata[IEN_OFS+B_ER]};
          default: ;
        endcase
      end
      flags <= flg_base | {blk_done, abort_p, err_p};
      irq   <= |(flags & ien);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      case (sel)
        R_CTRL: begin
          reg_rdata[B_EN]   <= cfg_en;
          reg_rdata[B_AUTO] <= cfg_auto;
          reg_rdata[B_EXT]  <= cfg_ext;
        end
        R_ECON: reg_rdata[B_PATEN] <= cfg_paten;
        R_INT: begin
          reg_rdata[B_BC] <= flags[2];
          reg_rdata[B_AB] <= flags[1];
          reg_rdata[B_ER] <= flags[0];
          reg_rdata[IEN_OFS+B_BC] <= ien[2];
          reg_rdata[IEN_OFS+B_AB] <= ien[1];
          reg_rdata[IEN_OFS+B_ER] <= ien[0];
        end
        R_SSA:  reg_rdata <= RW'(cfg_ssa);
        R_DSA:  reg_rdata <= RW'(cfg_dsa);
        R_SSZ:  reg_rdata <= RW'(cfg_ssz);
        R_DSZ:  reg_rdata <= RW'(cfg_dsz);
        R_SPTR: reg_rdata <= RW'(sptr_view);
        R_DPTR: reg_rdata <= RW'(dptr_view);
        R_CSZ:  reg_rdata <= RW'(cfg_csz);
        R_CPTR: reg_rdata <= RW'(cptr_view);
        R_PAT:  reg_rdata <= RW'(cfg_pat);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dmx_engine.sv
module dmx_engine #(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_en,
  input  logic            cfg_ext,
  input  logic            cfg_paten,
  input  logic [AW-1:0]   cfg_ssa,
  input  logic [AW-1:0]   cfg_dsa,
  input  logic [BW-1:0]   cfg_ssz,
  input  logic [BW-1:0]   cfg_dsz,
  input  logic [BW-1:0]   cfg_csz,
  input  logic [BW-1:0]   cfg_pat,
  input  logic            start_p,
  input  logic            abort_p,
  output logic            mem_re,
  output logic [AW-1:0]   mem_raddr,
  input  logic [BW-1:0]   mem_rdata,
  output logic            mem_we,
  output logic [AW-1:0]   mem_waddr,
  output logic [BW-1:0]   mem_wdata,
  output logic            blk_done,
  output logic            busy,
  output logic [BW-1:0]   sptr_view,
  output logic [2*BW-1:0] dptr_view,
  output logic [BW:0]     cptr_view
);
  localparam int PW = 2 * BW;
  localparam int CW = PW + 1;
  localparam int SW = BW + 1;

  function automatic logic [SW-1:0] eff_len(input logic [BW-1:0] v);
    return (v == '0) ? (SW'(1) << BW) : {1'b0, v};
  endfunction

  logic          active;
  logic [CW-1:0] cnt, cnt_nx, blk_sz;
  logic [BW-1:0] sptr, dptr, sptr_nx, dptr_nx;
  logic [SW-1:0] cptr, s_eff, d_eff, c_eff, s1, d1, c1;
  logic [PW-1:0] src_ofs, dst_ofs;
  logic          move, pat_hit, last, cell_end;

  always_comb begin
    s_eff = eff_len(cfg_ssz);
    d_eff = eff_len(cfg_dsz);
    c_eff = eff_len(cfg_csz);
    if (cfg_ext)
      blk_sz = ({cfg_ssz, cfg_dsz} == '0) ? (CW'(1) << PW) : {1'b0, cfg_ssz, cfg_dsz};
    else
      blk_sz = CW'((s_eff > d_eff) ? s_eff : d_eff);
  end

  assign move     = cfg_en && active;
  assign pat_hit  = cfg_paten && (mem_rdata == cfg_pat);
  assign cnt_nx   = cnt + CW'(1);
  assign last     = move && ((cnt_nx == blk_sz) || pat_hit);
  assign s1       = {1'b0, sptr} + SW'(1);
  assign d1       = {1'b0, dptr} + SW'(1);
  assign c1       = cptr + SW'(1);
  assign sptr_nx  = (s1 == s_eff) ? '0 : s1[BW-1:0];
  assign dptr_nx  = (d1 == d_eff) ? '0 : d1[BW-1:0];
  assign cell_end = !cfg_ext && (c1 == c_eff);

  assign src_ofs  = cfg_ext ? cnt[PW-1:0] : {{BW{1'b0}}, sptr};
  assign dst_ofs  = cfg_ext ? cnt[PW-1:0] : {{BW{1'b0}}, dptr};
  assign mem_re   = move;
  assign mem_raddr = cfg_ssa + AW'(src_ofs);
  assign blk_done = last && !abort_p;
  assign busy     = active || (cnt != '0);

  assign sptr_view = cfg_ext ? cnt[PW-1:BW] : sptr;
  assign dptr_view = cfg_ext ? cnt[PW-1:0] : {{BW{1'b0}}, dptr};
  assign cptr_view = cptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= move && !abort_p;
      if (move) begin
        mem_waddr <= cfg_dsa + AW'(dst_ofs);
        mem_wdata <= mem_rdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || abort_p) begin
      active <= 1'b0;
      cnt    <= '0;
      sptr   <= '0;
      dptr   <= '0;
      cptr   <= '0;
    end else if (move) begin
      if (last) begin
        active <= 1'b0;
        cnt    <= '0;
        sptr   <= '0;
        dptr   <= '0;
        cptr   <= '0;
      end else begin
        cnt  <= cnt_nx;
        sptr <= sptr_nx;
        dptr <= dptr_nx;
        if (cell_end) begin
          active <= 1'b0;
          cptr   <= '0;
        end else if (!cfg_ext) begin
          cptr <= c1;
        end
      end
    end else if (start_p && cfg_en) begin
      active <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_ext_channel.sv
module dma_ext_channel import dmx_pkg::*; #(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter int RW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [RW-1:0]  reg_wdata,
  output logic [RW-1:0]  reg_rdata,
  output logic           mem_re,
  output logic [AW-1:0]  mem_raddr,
  input  logic [BW-1:0]  mem_rdata,
  output logic           mem_we,
  output logic [AW-1:0]  mem_waddr,
  output logic [BW-1:0]  mem_wdata,
  output logic           irq
);
  logic cfg_en, cfg_ext, cfg_auto, cfg_paten;
  logic [AW-1:0] cfg_ssa, cfg_dsa;
  logic [BW-1:0] cfg_ssz, cfg_dsz, cfg_csz, cfg_pat;
  logic start_p, abort_p, err_p, done_p, busy;
  logic [2:0] flags, ien;
  logic [BW-1:0]   sptr_view;
  logic [2*BW-1:0] dptr_view;
  logic [BW:0]     cptr_view;

  dmx_regs #(.AW(AW), .BW(BW), .RW(RW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sptr_view(sptr_view), .dptr_view(dptr_view), .cptr_view(cptr_view),
    .busy(busy), .blk_done(done_p),
    .cfg_en(cfg_en), .cfg_ext(cfg_ext), .cfg_auto(cfg_auto), .cfg_paten(cfg_paten),
    .cfg_ssa(cfg_ssa), .cfg_dsa(cfg_dsa), .cfg_ssz(cfg_ssz), .cfg_dsz(cfg_dsz),
    .cfg_csz(cfg_csz), .cfg_pat(cfg_pat),
    .start_p(start_p), .abort_p(abort_p), .err_p(err_p),
    .flags(flags), .ien(ien), .irq(irq)
  );

  dmx_engine #(.AW(AW), .BW(BW)) u_eng (
    .clk(clk), .rst(rst),
    .cfg_en(cfg_en), .cfg_ext(cfg_ext), .cfg_paten(cfg_paten),
    .cfg_ssa(cfg_ssa), .cfg_dsa(cfg_dsa), .cfg_ssz(cfg_ssz), .cfg_dsz(cfg_dsz),
    .cfg_csz(cfg_csz), .cfg_pat(cfg_pat),
    .start_p(start_p), .abort_p(abort_p),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .blk_done(done_p), .busy(busy),
    .sptr_view(sptr_view), .dptr_view(dptr_view), .cptr_view(cptr_view)
  );
endmodule

// File: rtl/dmx_chk.sv
module dmx_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic       mem_re,
  input logic       mem_we,
  input logic       cfg_en,
  input logic       cfg_auto,
  input logic       done_p,
  input logic       abort_p,
  input logic       start_p,
  input logic [2:0] flags,
  input logic [2:0] ien,
  input logic       irq
);
  AST_WE_FOLLOWS_RE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(mem_re)); // R11
  AST_RE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> cfg_en); // R7
  AST_IDLE_FORCE_NO_RUN: assert property (@(posedge clk) disable iff (rst)
    (start_p && !cfg_en) |=> (!mem_re && flags[0])); // R7
  AST_ABORT_HALTS: assert property (@(posedge clk) disable iff (rst)
    abort_p |=> (!mem_re && !mem_we && flags[1])); // R9
  AST_DONE_DROPS_EN: assert property (@(posedge clk) disable iff (rst)
    (done_p && !cfg_auto && !reg_wr) |=> !cfg_en); // R6
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    done_p |=> flags[2]); // R6
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(flags & ien))); // R10
endmodule

bind dma_ext_channel dmx_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .mem_re(mem_re), .mem_we(mem_we),
  .cfg_en(cfg_en), .cfg_auto(cfg_auto), .done_p(done_p), .abort_p(abort_p),
  .start_p(start_p), .flags(flags), .ien(ien), .irq(irq)
);

// File: tb/dma_ext_channel_tb.sv
`timescale 1ns/1ps
module dma_ext_channel_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mem_re, mem_we, irq;
  logic [15:0] mem_raddr, mem_waddr;
  logic [7:0]  mem_rdata, mem_wdata;

  always #2 clk = ~clk;

  function automatic logic [7:0] src_byte(input logic [15:0] a);
    return a[7:0] ^ {a[10:8], a[15:11]} ^ 8'hA5;
  endfunction

  assign mem_rdata = src_byte(mem_raddr);

  dma_ext_channel u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .irq(irq)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] t_ssa = '0, t_dsa = '0;
  int t_ss = 1, t_ds = 1;
  bit t_ext = 1'b0;
  int wi = 0, bad = 0, first_c = 0, last_c = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst && mem_we) begin
      logic [15:0] ea, sa;
      sa = t_ext ? 16'(t_ssa + wi) : 16'(t_ssa + (wi % t_ss));
      ea = t_ext ? 16'(t_dsa + wi) : 16'(t_dsa + (wi % t_ds));
      if (mem_waddr != ea || mem_wdata != src_byte(sa)) bad++;
      if (wi == 0) first_c = cyc;
      last_c = cyc;
      wi++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rptr(input logic [3:0] a, output logic [15:0] d, output int rec);
    @(negedge clk);
    #1;
    reg_addr = a;
    rec = wi;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] ssa, input logic [15:0] dsa,
                       input logic [7:0] ssz, input logic [7:0] dsz, input bit ext);
    t_ssa = ssa; t_dsa = dsa; t_ext = ext;
    t_ss = (ssz == 0) ? 256 : int'(ssz);
    t_ds = (dsz == 0) ? 256 : int'(dsz);
    wi = 0; bad = 0;
    wreg(4'd3, ssa); wreg(4'd4, dsa);
    wreg(4'd5, {8'h0, ssz}); wreg(4'd6, {8'h0, dsz});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int rec, n, j;
    logic [7:0] pat;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rreg(4'd0, v);  chk(v == 0, "R1", "ctrl", v, 0);
    rreg(4'd2, v);  chk(v == 0, "R1", "int", v, 0);
    rreg(4'd8, v);  chk(v == 0, "R1", "dptr", v, 0);
    chk(irq == 0 && wi == 0, "R1", "irq/writes", wi, 0);

    // R7 force while disabled
    wreg(4'd1, 16'h0080); idle(4);
    rreg(4'd2, v);  chk(v[0] == 1 && wi == 0, "R7", "error flag", v, 1);
    wreg(4'd2, 16'h0000);

    // R2 normal mode, unequal sizes
    setup(16'h1000, 16'h2000, 8'd5, 8'd12, 0);
    wreg(4'd9, 16'h0000);
    wreg(4'd0, 16'h0080); wreg(4'd1, 16'h0080); idle(16);
    chk(wi == 12 && bad == 0, "R2", "normal copy count", wi, 12);
    chk(last_c - first_c == 11, "R11", "no gaps", last_c - first_c, 11);
    rreg(4'd2, v);  chk(v[3] == 1, "R6", "done flag", v[3], 1);
    rreg(4'd0, v);  chk(v[7] == 0, "R6", "enable cleared", v[7], 0);
    wreg(4'd2, 16'h0000);

    // R3 cells
    setup(16'h0400, 16'h0800, 8'd20, 8'd20, 0);
    wreg(4'd9, 16'd8);
    wreg(4'd0, 16'h0080); wreg(4'd1, 16'h0080); idle(12);
    chk(wi == 8, "R3", "first cell", wi, 8);
    rreg(4'd0, v);  chk(v[7] == 1, "R3", "enable kept between cells", v[7], 1);
    wreg(4'd1, 16'h0080); idle(12);
    chk(wi == 16, "R3", "second cell", wi, 16);
    wreg(4'd1, 16'h0080); idle(12);
    chk(wi == 20 && bad == 0, "R3", "last partial cell", wi, 20);
    wreg(4'd2, 16'h0000);

    // R4 extended 300 bytes, cell size ignored, auto-enable R6
    setup(16'h3100, 16'h7000, 8'h01, 8'h2C, 1);
    wreg(4'd9, 16'd4);
    wreg(4'd0, 16'h0098); wreg(4'd1, 16'h0080); idle(306);
    chk(wi == 300 && bad == 0, "R4", "extended length", wi, 300);
    rreg(4'd0, v);  chk(v[7] == 1, "R6", "auto keeps enable", v[7], 1);
    rreg(4'd2, v);  chk(v[3] == 1, "R6", "auto done flag", v[3], 1);
    wreg(4'd0, 16'h0008); wreg(4'd2, 16'h0000);

    // R5 pointer views, then R9 abort
    setup(16'h0010, 16'h9000, 8'h04, 8'h00, 1);
    wreg(4'd0, 16'h0088); wreg(4'd1, 16'h0080); idle(600);
    rptr(4'd8, v, rec); chk(v == 16'(rec), "R5", "dptr full count", v, rec);
    rptr(4'd7, v, rec); chk(v == 16'(rec >> 8), "R5", "sptr high byte", v, rec >> 8);
    wreg(4'd0, 16'h0008); idle(3);
    n = wi; idle(10);
    chk(wi == n && n < 1024, "R9", "abort stops writes", wi, n);
    rreg(4'd2, v);  chk(v[1] == 1, "R9", "abort flag", v[1], 1);
    rreg(4'd8, v);  chk(v == 0, "R9", "pointer reset", v, 0);
    chk(bad == 0, "R4", "extended addresses", bad, 0);
    wreg(4'd2, 16'h0000);

    // R8 pattern stop
    setup(16'h5000, 16'h6000, 8'h00, 8'hC8, 1);
    pat = src_byte(16'h5000 + 16'd37);
    j = 0;
    while (src_byte(16'(16'h5000 + j)) != pat) j++;
    wreg(4'd11, {8'h0, pat});
    wreg(4'd0, 16'h0088); wreg(4'd1, 16'h00A0); idle(210);
    chk(wi == j + 1 && bad == 0, "R8", "pattern stop", wi, j + 1);
    rreg(4'd2, v);  chk(v[3] == 1, "R8", "pattern completes block", v[3], 1);
    wreg(4'd1, 16'h0000); wreg(4'd2, 16'h0000);

    // R10 interrupt
    wreg(4'd2, 16'h0800);
    chk(irq == 0, "R10", "irq idle", irq, 0);
    setup(16'h0100, 16'h0200, 8'd3, 8'd3, 0);
    wreg(4'd9, 16'h0000);
    wreg(4'd0, 16'h0080); wreg(4'd1, 16'h0080); idle(8);
    chk(irq == 1, "R10", "irq on done", irq, 1);
    wreg(4'd2, 16'h0800); idle(2);
    chk(irq == 0, "R10", "irq cleared", irq, 0);
    wreg(4'd2, 16'h0000);

    // R2/R11 random normal transfers
    for (int k = 0; k < 6; k++) begin
      logic [7:0] a, b;
      a = 8'($urandom_range(1, 40));
      b = 8'($urandom_range(1, 40));
      setup(16'($urandom), 16'($urandom), a, b, 0);
      n = (a > b) ? int'(a) : int'(b);
      wreg(4'd0, 16'h0080); wreg(4'd1, 16'h0080); idle(n + 6);
      chk(wi == n && bad == 0, "R2", "random copy", wi, n);
      chk(last_c - first_c == n - 1, "R11", "random no gaps", last_c - first_c, n - 1);
      wreg(4'd2, 16'h0000);
    end

    // R4 zero size in extended mode = 65536
    setup(16'h1234, 16'h8000, 8'h00, 8'h00, 1);
    wreg(4'd0, 16'h0088); wreg(4'd1, 16'h0080); idle(65542);
    chk(wi == 65536 && bad == 0, "R4", "zero means 65536", wi, 65536);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule